// File: doc/BRIEF.md
# Matrix keyboard scan controller

This block scans a key matrix of up to sixteen rows and eight columns. It drives one row high at a time and reads the column lines. A key counts as closed only when its column reads high for a whole debounce window. Each closed key becomes a one-byte entry, and the entries collect in an eight-deep store. Software reads the store through two 32-bit entry words on a simple register bus.

Scanning runs in fixed frames. A short lead-in comes first, then every row in turn, then a programmable repeat gap, and then the next frame starts. A key that stays held is reported again in every frame. The store empties when a whole frame finds no key closed. An interrupt fires when the entry count reaches a programmed threshold. A one-cycle wake pulse marks any closed key that its row mask does not suppress.

Top module: `keymat_scan_top`

## Requirements
- R1: An entry byte holds the valid flag in bit 7, the row number in bits 6:3 and the column number in bits 2:0. Entry word A at 0x0C holds entries 0 to 3, with entry 0 in bits 7:0. Entry word B at 0x10 holds entries 4 to 7. Slots at or above the current count read as zero.
- R2: The control register at 0x00 holds scan enable in bit 0, the interrupt enable in bit 3, the debounce count in bits 13:4 and the threshold in bits 17:14. Every register resets to zero. While enable is 0 no row is driven, and the stored entries are kept.
- R3: After enable is set, one idle cycle and a lead-in of five cycles pass with no row driven. Then rows 0 to 15 are driven in order, one-hot and active high, for 16 plus debounce cycles each. A gap of the repeat count held in 0x08 bits 15:0 follows, and then the next lead-in.
- R4: A key is recorded only if its column reads high on each of the last debounce+1 cycles of its row's drive window.
- R5: Within a frame, keys are appended in ascending row order, and within a row in ascending column order.
- R6: A key held through consecutive frames is appended again in each frame. A frame that finds no closed key empties the store.
- R7: The store holds at most eight entries. When it is full, further entries are dropped and the stored ones are left unchanged.
- R8: A read of entry word B returns the current entries and then empties the store. A read of entry word A leaves the store unchanged.
- R9: The status register at 0x04 shows the entry count in bits 7:4 and a threshold flag in bit 2. The flag sets while the threshold is nonzero and the count is at or above it. Writing 1 to bit 2 clears the flag. irq equals the flag ANDed with the interrupt enable.
- R10: The mask for row r is at 0x40+4*r, and bit c set suppresses wake for column c. wake pulses for one cycle at the end of a row window that holds a closed key not suppressed by its mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Byte address of register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| col_sense | input | NCOL | Column lines, high when a closed key joins the driven row |
| row_drive | output | NROW | One-hot row drive, active high |
| irq | output | 1 | Threshold interrupt |
| wake | output | 1 | Wake pulse for an unmasked closed key |

## Verification
The state hardest to reach is a key that flickers within its own row's sampling window while a steady key elsewhere is still reported. The bench toggles one column bit on every clock, but only while that row is driven, so the toggle always falls inside the debounce window. The overflow and flush cases need the store to carry contents across frames without any pop between them. The bench gets there by turning enable off and on, which restarts the frame at a known cycle and leaves the store as it was.

// File: rtl/keymat_pkg.sv
package keymat_pkg;

    localparam int ROW_W      = 4;
    localparam int COL_W      = 3;
    localparam int ROW_SETTLE = 16;
    localparam int LEAD_IN    = 5;

    localparam logic [7:0] ADDR_CTRL   = 8'h00;
    localparam logic [7:0] ADDR_STATUS = 8'h04;
    localparam logic [7:0] ADDR_REPEAT = 8'h08;
    localparam logic [7:0] ADDR_ENT_A  = 8'h0C;
    localparam logic [7:0] ADDR_ENT_B  = 8'h10;
    localparam logic [1:0] MASK_PAGE   = 2'b01;

    typedef struct packed {
        logic             vld;
        logic [ROW_W-1:0] row;
        logic [COL_W-1:0] col;
    } entry_t;

    typedef struct packed {
        logic [13:0] rsvd_hi;
        logic [3:0]  thr;
        logic [9:0]  db;
        logic        ien;
        logic [1:0]  rsvd_lo;
        logic        en;
    } ctrl_t;

    typedef enum logic [1:0] {
        SC_IDLE,
        SC_LEAD,
        SC_ROW,
        SC_GAP
    } scan_state_e;

    function automatic entry_t make_entry(input logic [ROW_W-1:0] r,
                                          input logic [COL_W-1:0] c);
        entry_t e;
        e.vld = 1'b1;
        e.row = r;
        e.col = c;
        return e;
    endfunction

    function automatic ctrl_t ctrl_from_word(input logic [31:0] w);
        ctrl_t c;
        c = ctrl_t'(w);
        c.rsvd_hi = '0;
        c.rsvd_lo = '0;
        return c;
    endfunction

endpackage

// File: rtl/keymat_scanner.sv
module keymat_scanner
    import keymat_pkg::*;
#(
    parameter int NROW = 16,
    parameter int NCOL = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [9:0]       db,
    input  logic [15:0]      rpt,
    input  logic [NCOL-1:0]  col_sense,
    output logic [NROW-1:0]  row_drive,
    output logic             row_done,
    output logic             last_row,
    output logic [ROW_W-1:0] done_row,
    output logic [NCOL-1:0]  closed
);

    localparam logic [ROW_W-1:0] LAST_IDX = ROW_W'(NROW - 1);

    scan_state_e      st;
    logic [15:0]      cnt;
    logic [ROW_W-1:0] row;
    logic [NCOL-1:0]  acc;
    logic [15:0]      row_len;
    logic             in_window;

    assign row_len   = 16'(ROW_SETTLE) + {6'd0, db};
    assign in_window = (cnt >= 16'(ROW_SETTLE - 1));

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            st  <= SC_IDLE;
            cnt <= '0;
            row <= '0;
            acc <= '1;
        end else begin
            unique case (st)
                SC_IDLE: begin
                    st  <= SC_LEAD;
                    cnt <= '0;
                end
                SC_LEAD: begin
                    if (cnt == 16'(LEAD_IN - 1)) begin
                        st  <= SC_ROW;
                        cnt <= '0;
                        row <= '0;
                        acc <= '1;
                    end else begin
                        cnt <= cnt + 16'd1;
                    end
                end
                SC_ROW: begin
                    if (cnt == row_len - 16'd1) begin
                        cnt <= '0;
                        acc <= '1;
                        if (row == LAST_IDX) begin
                            st  <= (rpt == 16'd0) ? SC_LEAD : SC_GAP;
                            row <= '0;
                        end else begin
                            row <= row + ROW_W'(1);
                        end
                    end else begin
                        cnt <= cnt + 16'd1;
                        if (in_window) acc <= acc & col_sense;
                    end
                end
                SC_GAP: begin
                    if (cnt == rpt - 16'd1) begin
                        st  <= SC_LEAD;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + 16'd1;
                    end
                end
                default: st <= SC_IDLE;
            endcase
        end
    end

    generate
        for (genvar r = 0; r < NROW; r++) begin : g_drive
            assign row_drive[r] = (st == SC_ROW) && (row == ROW_W'(r));
        end
    endgenerate

    assign row_done = en && (st == SC_ROW) && (cnt == row_len - 16'd1);
    assign last_row = (row == LAST_IDX);
    assign done_row = row;
    assign closed   = acc & col_sense;

    p_row_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (en && st == SC_ROW && !row_done) |=> $stable(row_drive))
        else $error("row drive changed inside a row window");

endmodule

// File: rtl/keymat_emitter.sv
module keymat_emitter
    import keymat_pkg::*;
#(
    parameter int NCOL = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [ROW_W-1:0] load_row,
    input  logic [NCOL-1:0]  load_cols,
    output logic             push,
    output entry_t           push_e
);

    logic [NCOL-1:0]  pend;
    logic [NCOL-1:0]  pick;
    logic [ROW_W-1:0] prow;
    logic [COL_W-1:0] idx;

    assign pick = pend & (~pend + NCOL'(1));

    always_comb begin
        idx = '0;
        for (int j = NCOL - 1; j >= 0; j--) begin
            if (pend[j]) idx = COL_W'(j);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= '0;
            prow <= '0;
        end else if (load) begin
            pend <= load_cols;
            prow <= load_row;
        end else begin
            pend <= pend & ~pick;
        end
    end

    assign push   = |pend;
    assign push_e = make_entry(prow, idx);

    p_emit_drained_r5: assert property (@(posedge clk) disable iff (rst)
        load |-> (pend == '0))
        else $error("new row loaded before previous row was emitted");

endmodule

// File: rtl/keymat_fifo.sv
module keymat_fifo
    import keymat_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       push,
    input  entry_t                     push_e,
    input  logic                       pop,
    input  logic                       flush,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic [DEPTH*8-1:0]         view
);

    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int IDX_W = $clog2(DEPTH);

    entry_t slot [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
            for (int i = 0; i < DEPTH; i++) slot[i] <= '0;
        end else if (pop || flush) begin
            count <= push ? CNT_W'(1) : '0;
            if (push) slot[0] <= push_e;
        end else if (push && (count < CNT_W'(DEPTH))) begin
            slot[count[IDX_W-1:0]] <= push_e;
            count <= count + CNT_W'(1);
        end
    end

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_view
            assign view[i*8 +: 8] = (CNT_W'(i) < count) ? slot[i] : 8'h00;
        end
    endgenerate

    p_count_bound_r7: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(DEPTH))
        else $error("entry count above depth");

    p_full_keep_r7: assert property (@(posedge clk) disable iff (rst)
        (push && !pop && !flush && count == CNT_W'(DEPTH)) |=> ($stable(count) && $stable(view)))
        else $error("full store changed on push");

    p_pop_empty_r8: assert property (@(posedge clk) disable iff (rst)
        (pop && !push) |=> (count == '0))
        else $error("store not empty after pop");

endmodule

// File: rtl/keymat_scan_top.sv
module keymat_scan_top
    import keymat_pkg::*;
#(
    parameter int NROW  = 16,
    parameter int NCOL  = 8,
    parameter int DEPTH = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            bus_wr,
    input  logic            bus_rd,
    input  logic [7:0]      bus_addr,
    input  logic [31:0]     bus_wdata,
    output logic [31:0]     bus_rdata,
    input  logic [NCOL-1:0] col_sense,
    output logic [NROW-1:0] row_drive,
    output logic            irq,
    output logic            wake
);

    localparam int CNT_W = $clog2(DEPTH + 1);

    ctrl_t             ctrl;
    logic [15:0]       rpt;
    logic [NCOL-1:0]   mask [NROW];
    logic              flag;
    logic              hit;
    logic              wake_q;
    logic [31:0]       rdata_q;

    logic              row_done;
    logic              last_row;
    logic [ROW_W-1:0]  done_row;
    logic [NCOL-1:0]   closed;
    logic              push;
    entry_t            push_e;
    logic              pop;
    logic              flush;
    logic [CNT_W-1:0]  count;
    logic [DEPTH*8-1:0] view;
    logic [63:0]       view64;
    logic [3:0]        count4;
    logic              thr_hit;
    logic              w1c;

    keymat_scanner #(.NROW(NROW), .NCOL(NCOL)) u_scan (
        .clk       (clk),
        .rst       (rst),
        .en        (ctrl.en),
        .db        (ctrl.db),
        .rpt       (rpt),
        .col_sense (col_sense),
        .row_drive (row_drive),
        .row_done  (row_done),
        .last_row  (last_row),
        .done_row  (done_row),
        .closed    (closed)
    );

    keymat_emitter #(.NCOL(NCOL)) u_emit (
        .clk       (clk),
        .rst       (rst),
        .load      (row_done),
        .load_row  (done_row),
        .load_cols (closed),
        .push      (push),
        .push_e    (push_e)
    );

    keymat_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk    (clk),
        .rst    (rst),
        .push   (push),
        .push_e (push_e),
        .pop    (pop),
        .flush  (flush),
        .count  (count),
        .view   (view)
    );

    assign pop     = bus_rd && (bus_addr == ADDR_ENT_B);
    assign flush   = row_done && last_row && !(hit || (|closed));
    assign view64  = 64'(view);
    assign count4  = 4'(count);
    assign thr_hit = (ctrl.thr != 4'd0) && (count4 >= ctrl.thr);
    assign w1c     = bus_wr && (bus_addr == ADDR_STATUS) && bus_wdata[2];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
            rpt  <= '0;
            for (int r = 0; r < NROW; r++) mask[r] <= '0;
        end else if (bus_wr) begin
            if (bus_addr == ADDR_CTRL)   ctrl <= ctrl_from_word(bus_wdata);
            if (bus_addr == ADDR_REPEAT) rpt  <= bus_wdata[15:0];
            for (int r = 0; r < NROW; r++) begin
                if (bus_addr[7:6] == MASK_PAGE && bus_addr[5:2] == 4'(r))
                    mask[r] <= bus_wdata[NCOL-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !ctrl.en) begin
            hit <= 1'b0;
        end else if (row_done) begin
            hit <= last_row ? 1'b0 : (hit || (|closed));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
        end else if (thr_hit) begin
            flag <= 1'b1;
        end else if (w1c) begin
            flag <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wake_q <= 1'b0;
        end else begin
            wake_q <= row_done && (|(closed & ~mask[done_row]));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
        end else if (bus_rd) begin
            rdata_q <= '0;
            if (bus_addr == ADDR_CTRL)   rdata_q <= ctrl;
            if (bus_addr == ADDR_STATUS) rdata_q <= {24'd0, count4, 1'b0, flag, 2'b00};
            if (bus_addr == ADDR_REPEAT) rdata_q <= {16'd0, rpt};
            if (bus_addr == ADDR_ENT_A)  rdata_q <= view64[31:0];
            if (bus_addr == ADDR_ENT_B)  rdata_q <= view64[63:32];
            for (int r = 0; r < NROW; r++) begin
                if (bus_addr[7:6] == MASK_PAGE && bus_addr[5:2] == 4'(r))
                    rdata_q <= 32'(mask[r]);
            end
        end
    end

    assign bus_rdata = rdata_q;
    assign irq       = flag && ctrl.ien;
    assign wake      = wake_q;

    p_row_onehot_r3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(row_drive))
        else $error("more than one row driven");

    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        !ctrl.en |=> (row_drive == '0))
        else $error("row driven while disabled");

    p_flag_follows_r9: assert property (@(posedge clk) disable iff (rst)
        thr_hit |=> flag)
        else $error("threshold reached but flag not set");

    p_wake_after_row_r10: assert property (@(posedge clk) disable iff (rst)
        wake |-> $past(row_done))
        else $error("wake pulse outside row end");

endmodule

// File: tb/keymat_scan_top_tb.sv
module keymat_scan_top_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NROW = 16;
    localparam int NCOL = 8;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            bus_wr = 1'b0;
    logic            bus_rd = 1'b0;
    logic [7:0]      bus_addr = '0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic [NCOL-1:0] col_sense;
    logic [NROW-1:0] row_drive;
    logic            irq;
    logic            wake;

    logic [NCOL-1:0] keys [NROW];
    logic            glitch = 1'b0;
    logic            glitch_on = 1'b0;
    int              checks = 0;
    int              errors = 0;
    int              wake_cnt = 0;
    logic [7:0]      exp_e [32];
    int              exp_n;
    logic [31:0]     exp_a, exp_b;

    keymat_scan_top #(.NROW(NROW), .NCOL(NCOL), .DEPTH(8)) u_dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .col_sense(col_sense), .row_drive(row_drive), .irq(irq), .wake(wake)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    always_comb begin
        col_sense = '0;
        for (int r = 0; r < NROW; r++)
            if (row_drive[r]) col_sense = col_sense | keys[r];
        if (row_drive[4] && glitch) col_sense[3] = 1'b1;
    end

    always @(negedge clk) begin
        if (glitch_on) glitch <= ~glitch;
        else glitch <= 1'b0;
        if (wake) wake_cnt <= wake_cnt + 1;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FIFO-CHECK FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    function automatic logic [31:0] ctl(input bit en, input bit ien,
                                        input int db, input int thr);
        return {14'd0, 4'(thr), 10'(db), ien, 2'b00, en};
    endfunction

    task automatic clear_keys();
        for (int r = 0; r < NROW; r++) keys[r] = '0;
    endtask

    task automatic gather(input int copies);
        int n1;
        exp_n = 0;
        for (int r = 0; r < NROW; r++)
            for (int c = 0; c < NCOL; c++)
                if (keys[r][c] && exp_n < 16) begin
                    exp_e[exp_n] = {1'b1, 4'(r), 3'(c)};
                    exp_n++;
                end
        n1 = exp_n;
        if (copies == 2) begin
            for (int i = 0; i < n1; i++) exp_e[n1 + i] = exp_e[i];
            exp_n = 2 * n1;
        end
        if (exp_n > 8) exp_n = 8;
        exp_a = '0; exp_b = '0;
        for (int i = 0; i < 4; i++) if (i < exp_n) exp_a[i*8 +: 8] = exp_e[i];
        for (int i = 4; i < 8; i++) if (i < exp_n) exp_b[(i-4)*8 +: 8] = exp_e[i];
    endtask

    // run frames from a fixed start; pop first when asked, freeze afterwards
    task automatic run_frames(input bit do_pop, input int frames, input int db,
                              input int rpt, input bit ien, input int thr);
        logic [31:0] d;
        int rw;
        rw = 16 + db;
        wr(8'h00, ctl(0, ien, db, thr));
        wr(8'h08, 32'(rpt));
        if (do_pop) rd(8'h10, d);
        wr(8'h00, ctl(1, ien, db, thr));
        if (frames == 1) repeat (6 + NROW * rw + 10) @(negedge clk);
        else repeat (11 + 2 * NROW * rw + rpt + 10) @(negedge clk);
        wr(8'h00, ctl(0, ien, db, thr));
    endtask

    task automatic check_store(input string req);
        logic [31:0] d;
        rd(8'h04, d);
        chk(req, {28'd0, d[7:4]}, 32'(exp_n));
        rd(8'h0C, d);
        chk(req, d, exp_a);
        rd(8'h04, d);
        chk(req, {28'd0, d[7:4]}, 32'(exp_n));
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("WATCHDOG FAIL timeout actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] d;
        int n;
        void'($urandom(32'd4711));
        clear_keys();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R2 reset state
        chk("R2 rows idle", 32'(row_drive), 32'd0);
        chk("R2 irq", 32'(irq), 32'd0);
        rd(8'h00, d); chk("R2 ctrl reset", d, 32'd0);
        rd(8'h04, d); chk("R2 status reset", d, 32'd0);
        rd(8'h0C, d); chk("R1 empty word A", d, 32'd0);

        // R3 lead-in and row window length, db = 2
        wr(8'h00, ctl(1, 0, 2, 0));
        n = 0;
        while (row_drive == '0 && n < 100) begin n++; @(negedge clk); end
        chk("R3 lead-in cycles", 32'(n), 32'd6);
        chk("R3 row0 first", 32'(row_drive), 32'h1);
        n = 0;
        while (row_drive == 16'h1 && n < 100) begin n++; @(negedge clk); end
        chk("R3 row window", 32'(n), 32'd18);
        chk("R3 row1 next", 32'(row_drive), 32'h2);
        wr(8'h00, ctl(0, 0, 2, 0));
        @(negedge clk);
        chk("R2 disabled no drive", 32'(row_drive), 32'd0);

        // R1 R5 directed frame
        clear_keys();
        keys[0][5] = 1; keys[3][1] = 1; keys[3][6] = 1; keys[15][7] = 1;
        run_frames(1, 1, 2, 3, 0, 0);
        gather(1);
        check_store("R1 R5 directed");
        rd(8'h0C, d); chk("R8 word A no pop", d, exp_a);
        rd(8'h10, d); chk("R8 word B read", d, exp_b);
        rd(8'h04, d); chk("R8 empty after pop", {28'd0, d[7:4]}, 32'd0);

        // R6 re-report over two frames
        clear_keys();
        keys[2][0] = 1; keys[9][4] = 1;
        run_frames(1, 2, 1, 2, 0, 0);
        gather(2);
        check_store("R6 re-report");
        rd(8'h10, d); chk("R6 word B", d, exp_b);

        // R6 empty frame flushes retained entries
        run_frames(1, 1, 1, 2, 0, 0);
        rd(8'h04, d); chk("R6 refilled", {28'd0, d[7:4]}, 32'd2);
        clear_keys();
        run_frames(0, 1, 1, 2, 0, 0);
        rd(8'h04, d); chk("R6 flush on empty frame", {28'd0, d[7:4]}, 32'd0);

        // R7 overflow drops tail, full store kept across a frame
        clear_keys();
        keys[1] = 8'hFF; keys[5][2] = 1; keys[6][0] = 1; keys[6][7] = 1;
        run_frames(1, 1, 0, 0, 0, 0);
        gather(1);
        check_store("R7 overflow");
        rd(8'h10, d); chk("R7 word B before refill", d, exp_b);
        run_frames(0, 1, 0, 0, 0, 0);
        gather(1);
        clear_keys();
        keys[12][3] = 1;
        run_frames(0, 1, 0, 0, 0, 0);
        check_store("R7 full kept");

        // R4 flickering key in the sample window is rejected
        clear_keys();
        keys[7][0] = 1;
        glitch_on = 1'b1;
        run_frames(1, 1, 2, 1, 0, 0);
        glitch_on = 1'b0;
        gather(1);
        check_store("R4 debounce reject");

        // R9 threshold interrupt and write-one-to-clear
        clear_keys();
        keys[4][4] = 1; keys[10][1] = 1;
        run_frames(1, 1, 0, 1, 1, 3);
        rd(8'h04, d); chk("R9 flag below thr", 32'(d[2]), 32'd0);
        chk("R9 irq below thr", 32'(irq), 32'd0);
        run_frames(0, 1, 0, 1, 1, 3);
        rd(8'h04, d); chk("R9 count", {28'd0, d[7:4]}, 32'd4);
        chk("R9 flag set", 32'(d[2]), 32'd1);
        chk("R9 irq set", 32'(irq), 32'd1);
        rd(8'h10, d);
        wr(8'h04, 32'h4);
        rd(8'h04, d); chk("R9 w1c clears", 32'(d[2]), 32'd0);
        chk("R9 irq clear", 32'(irq), 32'd0);

        // R10 wake masking
        clear_keys();
        keys[2][4] = 1;
        wr(8'h48, 32'h10);
        rd(8'h48, d); chk("R10 mask readback", d, 32'h10);
        wake_cnt = 0;
        run_frames(1, 1, 0, 0, 0, 0);
        chk("R10 masked no wake", 32'(wake_cnt), 32'd0);
        rd(8'h04, d); chk("R10 still recorded", {28'd0, d[7:4]}, 32'd1);
        wr(8'h48, 32'h0);
        wake_cnt = 0;
        run_frames(1, 1, 0, 0, 0, 0);
        chk("R10 unmasked wake", 32'(wake_cnt), 32'd1);

        // R5 R1 random frames
        for (int it = 0; it < 8; it++) begin
            int nk, db, rp;
            clear_keys();
            nk = 1 + int'($urandom % 10);
            for (int k = 0; k < nk; k++) keys[$urandom % NROW][$urandom % NCOL] = 1'b1;
            db = int'($urandom % 4);
            rp = int'($urandom % 8);
            run_frames(1, 1, db, rp, 0, 0);
            gather(1);
            check_store("R5 random frame");
            rd(8'h10, d); chk("R1 random word B", d, exp_b);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule